// File: doc/BRIEF.md
# Control-Block Slot Cache Manager

The block keeps a small on-chip pool of slots. Each slot holds one transaction control block, and the transaction is known by an 8-bit tag. Through paging to host memory, more transactions can be outstanding than there are slots. A new transaction takes a free slot when one exists. When no slot is free, the manager chooses a disconnected transaction's slot, asks an external DMA engine to save that block to host memory, and then gives the slot to the new transaction. When a transaction reconnects and its block is no longer on chip, the manager picks a slot by the same rule, saving a victim first if it has to, and asks for a restore DMA. The slot becomes active once that restore is acknowledged.

The victim is always the disconnected slot whose transaction disconnected most recently. Such a transaction has just started a long absence, so it is the least likely to be needed soon. Recency is kept as a per-slot stamp taken from a counter that advances on every disconnect event.

Two request ports feed the block: a new-transaction port and an event port (disconnect, reconnect, complete). Both use valid/ready. A request is taken on a clock edge where valid and ready are both high. Both ready signals are low while a DMA operation is outstanding. The event port wins when both ports are valid, so new_ready is low whenever evt_valid is high. The DMA port is a plain req/ack pair, and only one operation is ever outstanding.

Top module: `slot_cache_mgr`

## Requirements
- R1: Synchronous reset marks every slot free and clears the disconnect counter. In the first cycle after reset, free_cnt equals NUM_SLOTS and dma_req, rsp_valid and busy are all low.
- R2: An accepted new request with a valid tag, taken while a slot is free, claims the lowest-index free slot. In the next cycle it reports rsp_valid=1, rsp_slot=that slot, rsp_hit=0 and rsp_err=0, and no DMA is issued.
- R3: An accepted new request taken while no slot is free, but with at least one disconnected slot, issues a save DMA (dma_restore=0) for the disconnected slot with the most recent disconnect. dma_slot and dma_tag carry that slot and its old tag. The cycle after the acknowledge, the response reports that slot with rsp_err=0.
- R4: A reconnect for a tag held in a slot makes that slot active. The next cycle it reports rsp_hit=1 with that slot, and no DMA is issued.
- R5: A reconnect for a tag not held on chip issues a restore DMA (dma_restore=1, dma_tag = the reconnecting tag) into the lowest free slot. With no free slot, it first saves the R3 victim and then restores into that same slot. The response after the last acknowledge has rsp_hit=0.
- R6: While dma_req is high without dma_ack, dma_req, dma_slot, dma_tag and dma_restore hold their values. busy is high from the cycle after acceptance until the response. While busy is high, new_ready and evt_ready are low and no request is taken.
- R7: A complete event for a tag held on chip frees its slot. A complete or disconnect for a tag not on chip leaves free_cnt unchanged.
- R8: A new request or a non-resident reconnect is refused with rsp_valid=1 and rsp_err=1, and with no DMA, in two cases: when no slot is free or disconnected, or when the tag is 255 (tags 0 to 254 are valid).
- R9: When evt_valid and new_valid are both high, the event is taken and new_ready is low. The new request is taken in a later cycle.
- R10: evt_kind encodes 0 = disconnect, 1 = reconnect, 2 = complete. Code 3 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| new_valid | input | 1 | New-transaction request valid |
| new_tag | input | TAG_W | Tag of the new transaction |
| new_ready | output | 1 | New request can be taken |
| evt_valid | input | 1 | Event valid |
| evt_kind | input | 2 | Event code (see R10) |
| evt_tag | input | TAG_W | Tag the event refers to |
| evt_ready | output | 1 | Event can be taken |
| dma_req | output | 1 | Save/restore DMA request |
| dma_restore | output | 1 | 1 = restore from host, 0 = save to host |
| dma_slot | output | SLOT_W | Slot index of the DMA operation |
| dma_tag | output | TAG_W | Tag whose block is moved |
| dma_ack | input | 1 | DMA engine acknowledge |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_slot | output | SLOT_W | Slot given to the transaction |
| rsp_hit | output | 1 | Reconnect found its block on chip |
| rsp_err | output | 1 | Request refused |
| busy | output | 1 | A DMA operation is outstanding |
| free_cnt | output | CNT_W | Number of free slots |

## Verification
On every cycle, the assertions check these properties:
- the DMA request stays stable until it is acknowledged;
- back-pressure holds while busy;
- events take priority over new requests;
- allocation from a free slot answers within one cycle without error;
- every refusal is a completed, idle response;
- the state right after reset is correct.

Only the bench scenarios can show three things, because they depend on the history of which tags were disconnected and when:
- victim choice by most recent disconnect;
- save-then-restore chaining on a non-resident reconnect;
- lowest-index free-slot order.

The bench scenarios also show that stray events and reserved codes leave the slot pool untouched, and that a reset in the middle of an operation drops the pending request.

// File: rtl/slot_cache_pkg.sv
package slot_cache_pkg;
  typedef enum logic [1:0] {
    SL_FREE   = 2'd0,
    SL_ACTIVE = 2'd1,
    SL_DISC   = 2'd2
  } slot_state_e;

  typedef enum logic [1:0] {
    EV_DISC  = 2'd0,
    EV_RECON = 2'd1,
    EV_DONE  = 2'd2,
    EV_NOP   = 2'd3
  } evt_kind_e;

  typedef enum logic [1:0] {
    MG_IDLE    = 2'd0,
    MG_SAVE    = 2'd1,
    MG_RESTORE = 2'd2
  } mgr_state_e;
endpackage

// File: rtl/slot_lookup.sv
module slot_lookup
  import slot_cache_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int TAG_W     = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  slot_state_e       st   [NUM_SLOTS],
  input  logic [TAG_W-1:0]  tags [NUM_SLOTS],
  input  logic [TAG_W-1:0]  key,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_idx,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_idx,
  output logic [CNT_W-1:0]  free_cnt
);
  // tag match over occupied slots
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (st[i] != SL_FREE && tags[i] == key && !hit) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(i);
      end
    end
  end

  // lowest free index wins: scan downward so the last write is the lowest
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    free_cnt = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (st[i] == SL_FREE) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
        free_cnt = free_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/victim_picker.sv
module victim_picker
  import slot_cache_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SEQ_W     = 16,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  slot_state_e       st     [NUM_SLOTS],
  input  logic [SEQ_W-1:0]  stamps [NUM_SLOTS],
  output logic              disc_any,
  output logic [SLOT_W-1:0] victim_idx
);
  logic [SEQ_W-1:0] best;

  // newest disconnect (largest stamp) among disconnected slots
  always_comb begin
    disc_any   = 1'b0;
    victim_idx = '0;
    best       = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (st[i] == SL_DISC && (!disc_any || stamps[i] > best)) begin
        disc_any   = 1'b1;
        best       = stamps[i];
        victim_idx = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/slot_cache_mgr.sv
module slot_cache_mgr
  import slot_cache_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int TAG_W     = 8,
  parameter int SEQ_W     = 16,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_valid,
  input  logic [TAG_W-1:0]  new_tag,
  output logic              new_ready,
  input  logic              evt_valid,
  input  logic [1:0]        evt_kind,
  input  logic [TAG_W-1:0]  evt_tag,
  output logic              evt_ready,
  output logic              dma_req,
  output logic              dma_restore,
  output logic [SLOT_W-1:0] dma_slot,
  output logic [TAG_W-1:0]  dma_tag,
  input  logic              dma_ack,
  output logic              rsp_valid,
  output logic [SLOT_W-1:0] rsp_slot,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic              busy,
  output logic [CNT_W-1:0]  free_cnt
);
  localparam logic [TAG_W-1:0] NIL_TAG = {TAG_W{1'b1}};

  slot_state_e       st_q    [NUM_SLOTS];
  logic [TAG_W-1:0]  tag_q   [NUM_SLOTS];
  logic [SEQ_W-1:0]  stamp_q [NUM_SLOTS];
  logic [SEQ_W-1:0]  seq_q;
  mgr_state_e        mst_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              pend_recon_q;

  logic              hit, free_any, disc_any;
  logic [SLOT_W-1:0] hit_idx, free_idx, victim_idx;

  slot_lookup #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_lookup (
    .st(st_q), .tags(tag_q), .key(evt_tag),
    .hit(hit), .hit_idx(hit_idx),
    .free_any(free_any), .free_idx(free_idx), .free_cnt(free_cnt)
  );

  victim_picker #(.NUM_SLOTS(NUM_SLOTS), .SEQ_W(SEQ_W)) u_victim (
    .st(st_q), .stamps(stamp_q),
    .disc_any(disc_any), .victim_idx(victim_idx)
  );

  // handshake: events win, nothing taken while a DMA is outstanding
  assign busy      = (mst_q != MG_IDLE);
  assign evt_ready = !busy;
  assign new_ready = !busy && !evt_valid;

  logic             evt_go, new_go, alloc_go, alloc_recon;
  logic [TAG_W-1:0] alloc_tag;
  evt_kind_e        kind;

  always_comb begin
    kind        = evt_kind_e'(evt_kind);
    evt_go      = evt_valid && evt_ready;
    new_go      = new_valid && new_ready;
    alloc_recon = evt_go && kind == EV_RECON && !hit;
    alloc_go    = new_go || alloc_recon;
    alloc_tag   = new_go ? new_tag : evt_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        st_q[i]    <= SL_FREE;
        tag_q[i]   <= '0;
        stamp_q[i] <= '0;
      end
      seq_q        <= '0;
      mst_q        <= MG_IDLE;
      pend_tag_q   <= '0;
      pend_recon_q <= 1'b0;
      dma_req      <= 1'b0;
      dma_restore  <= 1'b0;
      dma_slot     <= '0;
      dma_tag      <= '0;
      rsp_valid    <= 1'b0;
      rsp_slot     <= '0;
      rsp_hit      <= 1'b0;
      rsp_err      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      case (mst_q)
        MG_IDLE: begin
          if (evt_go && kind == EV_DISC) begin
            seq_q <= seq_q + SEQ_W'(1);
            if (hit && st_q[hit_idx] == SL_ACTIVE) begin
              st_q[hit_idx]    <= SL_DISC;
              stamp_q[hit_idx] <= seq_q;
            end
          end else if (evt_go && kind == EV_DONE) begin
            if (hit) st_q[hit_idx] <= SL_FREE;
          end else if (evt_go && kind == EV_RECON && hit) begin
            st_q[hit_idx] <= SL_ACTIVE;
            rsp_valid     <= 1'b1;
            rsp_slot      <= hit_idx;
            rsp_hit       <= 1'b1;
          end
          if (alloc_go) begin
            pend_tag_q   <= alloc_tag;
            pend_recon_q <= alloc_recon;
            if (alloc_tag == NIL_TAG || (!free_any && !disc_any)) begin
              rsp_valid <= 1'b1;
              rsp_slot  <= '0;
              rsp_err   <= 1'b1;
            end else if (free_any && !alloc_recon) begin
              st_q[free_idx]  <= SL_ACTIVE;
              tag_q[free_idx] <= alloc_tag;
              rsp_valid       <= 1'b1;
              rsp_slot        <= free_idx;
            end else if (free_any) begin
              mst_q       <= MG_RESTORE;
              dma_req     <= 1'b1;
              dma_restore <= 1'b1;
              dma_slot    <= free_idx;
              dma_tag     <= alloc_tag;
            end else begin
              mst_q       <= MG_SAVE;
              dma_req     <= 1'b1;
              dma_restore <= 1'b0;
              dma_slot    <= victim_idx;
              dma_tag     <= tag_q[victim_idx];
            end
          end
        end
        MG_SAVE: begin
          if (dma_ack) begin
            if (pend_recon_q) begin
              mst_q       <= MG_RESTORE;
              dma_restore <= 1'b1;
              dma_tag     <= pend_tag_q;
            end else begin
              mst_q           <= MG_IDLE;
              dma_req         <= 1'b0;
              st_q[dma_slot]  <= SL_ACTIVE;
              tag_q[dma_slot] <= pend_tag_q;
              rsp_valid       <= 1'b1;
              rsp_slot        <= dma_slot;
            end
          end
        end
        MG_RESTORE: begin
          if (dma_ack) begin
            mst_q           <= MG_IDLE;
            dma_req         <= 1'b0;
            st_q[dma_slot]  <= SL_ACTIVE;
            tag_q[dma_slot] <= pend_tag_q;
            rsp_valid       <= 1'b1;
            rsp_slot        <= dma_slot;
          end
        end
        default: mst_q <= MG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_cache_mgr_chk.sv
module slot_cache_mgr_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int TAG_W     = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              new_valid,
  input logic [TAG_W-1:0]  new_tag,
  input logic              new_ready,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              dma_req,
  input logic              dma_restore,
  input logic [SLOT_W-1:0] dma_slot,
  input logic [TAG_W-1:0]  dma_tag,
  input logic              dma_ack,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              busy,
  input logic [CNT_W-1:0]  free_cnt
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (free_cnt == CNT_W'(NUM_SLOTS) && !dma_req && !rsp_valid && !busy));

  a_r2_free_alloc: assert property (@(posedge clk) disable iff (rst)
    (new_valid && new_ready && free_cnt != '0 && new_tag != {TAG_W{1'b1}})
      |=> (rsp_valid && !rsp_err && !dma_req));

  a_r6_dma_hold: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack) |=> (dma_req && $stable(dma_slot) && $stable(dma_tag)
                               && $stable(dma_restore)));

  a_r6_busy_backpressure: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!new_ready && !evt_ready));

  a_r6_req_means_busy: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> busy);

  a_r8_refusal_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && !busy && !dma_req));

  a_r9_event_first: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> !new_ready);
endmodule

bind slot_cache_mgr slot_cache_mgr_chk #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .new_valid(new_valid), .new_tag(new_tag), .new_ready(new_ready),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .dma_req(dma_req),
  .dma_restore(dma_restore), .dma_slot(dma_slot), .dma_tag(dma_tag), .dma_ack(dma_ack),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .busy(busy), .free_cnt(free_cnt)
);

// File: tb/test_slot_cache_mgr.sv
module test_slot_cache_mgr;
  localparam int N = 4;

  typedef struct packed {
    logic [1:0] op;      // 0 disc, 1 recon, 2 complete, 3 new request
    logic [7:0] tag;
    logic       sv;      // save DMA seen
    logic [7:0] sv_slot;
    logic [7:0] sv_tag;
    logic       rs;      // restore DMA seen
    logic [7:0] rs_slot;
    logic [7:0] rs_tag;
    logic       rv;
    logic [7:0] slot;
    logic       hit;
    logic       err;
    logic [7:0] free;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{3, 10, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 3, 2},    // R2 slot0
    '{3, 11, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 2, 2},    // R2 slot1
    '{3, 12, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 1, 2},    // R2
    '{3, 13, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 2},    // R2
    '{0, 11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3},    // R3 stamp 0
    '{0, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3},    // R3 stamp 1
    '{0, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3},    // R3 stamp 2
    '{3, 20, 1, 0, 10, 0, 0, 0, 1, 0, 0, 0, 0, 3},   // R3 newest victim slot0
    '{1, 13, 0, 0, 0, 0, 0, 0, 1, 3, 1, 0, 0, 4},    // R4 hit
    '{1, 10, 1, 1, 11, 1, 1, 10, 1, 1, 0, 0, 0, 5},  // R5 save then restore
    '{2, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7},    // R7 frees slot2
    '{1, 11, 0, 0, 0, 1, 2, 11, 1, 2, 0, 0, 0, 5},   // R5 restore into free
    '{3, 30, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 8},    // R8 all active
    '{0, 20, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3},    // R3 stamp 3
    '{0, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3},    // R3 stamp 4
    '{3, 31, 1, 3, 13, 0, 0, 0, 1, 3, 0, 0, 0, 3},   // R3 victim slot3
    '{2, 99, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7},    // R7 stray complete
    '{0, 77, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7},    // R7 stray disconnect
    '{2, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7},    // R7 frees slot1
    '{3, 255, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 8},   // R8 tag 255
    '{3, 40, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 2},    // R2
    '{1, 20, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 4},    // R4
    '{1, 13, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 8},    // R8 reconnect refused
    '{2, 31, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7},    // R7
    '{2, 11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 7},    // R7
    '{3, 50, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 1, 2}     // R2 lowest free
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       new_valid = 1'b0, evt_valid = 1'b0, dma_ack = 1'b0;
  logic [7:0] new_tag = '0, evt_tag = '0;
  logic [1:0] evt_kind = '0;
  logic       new_ready, evt_ready, dma_req, dma_restore, rsp_valid, rsp_hit, rsp_err, busy;
  logic [1:0] dma_slot, rsp_slot;
  logic [7:0] dma_tag;
  logic [2:0] free_cnt;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  slot_cache_mgr #(.NUM_SLOTS(N), .TAG_W(8), .SEQ_W(16)) i_slot_cache_mgr (
    .clk(clk), .rst(rst), .new_valid(new_valid), .new_tag(new_tag), .new_ready(new_ready),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_tag(evt_tag), .evt_ready(evt_ready),
    .dma_req(dma_req), .dma_restore(dma_restore), .dma_slot(dma_slot), .dma_tag(dma_tag),
    .dma_ack(dma_ack), .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_hit(rsp_hit),
    .rsp_err(rsp_err), .busy(busy), .free_cnt(free_cnt)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] got,
                       input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // one request, service any DMA it raises, then sample the outcome
  task automatic do_op(input logic is_new, input logic [1:0] kind, input logic [7:0] t,
                       output vec_t g);
    g = '0;
    @(negedge clk);
    if (is_new) begin new_valid = 1'b1; new_tag = t; end
    else begin evt_valid = 1'b1; evt_kind = kind; evt_tag = t; end
    @(negedge clk);
    new_valid = 1'b0;
    evt_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (!dma_req) break;
      if (dma_restore) begin g.rs = 1'b1; g.rs_slot = 8'(dma_slot); g.rs_tag = dma_tag; end
      else begin g.sv = 1'b1; g.sv_slot = 8'(dma_slot); g.sv_tag = dma_tag; end
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
    end
    g.rv = rsp_valid;
    if (rsp_valid) begin
      g.err = rsp_err;
      g.hit = rsp_hit;
      g.slot = rsp_err ? 8'd0 : 8'(rsp_slot);
    end
    g.free = 8'(free_cnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    vec_t g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(free_cnt == 3'(N) && !busy && !dma_req && !rsp_valid && new_ready && evt_ready,
          "R1 reset", {free_cnt, busy, dma_req, rsp_valid, new_ready},
          {3'(N), 4'b0001});

    for (int i = 0; i < NV; i++) begin
      vec_t e;
      e = VECS[i];
      do_op(e.op == 2'd3, e.op, e.tag, g);
      g.op = e.op; g.tag = e.tag; g.req = e.req;
      check(g == e, $sformatf("R%0d vector %0d", e.req, i), 128'(g), 128'(e));
    end

    // state: slot0=20 active, slot1=40 active, slot2=50 active, slot3 free
    // R6 stall: disconnect 40, fill slot3, then a save held without ack
    do_op(1'b0, 2'd0, 8'd40, g);
    do_op(1'b1, 2'd0, 8'd60, g);
    check(g.rv && g.slot == 8'd3 && !g.sv, "R2 fill slot3", 128'(g.slot), 128'd3);
    @(negedge clk); new_valid = 1'b1; new_tag = 8'd61;
    @(negedge clk); new_valid = 1'b0;
    evt_valid = 1'b1; evt_kind = 2'd2; evt_tag = 8'd20;
    repeat (3) @(negedge clk);
    check(dma_req && !dma_restore && dma_slot == 2'd1 && dma_tag == 8'd40 && busy
          && !new_ready && !evt_ready && free_cnt == 3'd0,
          "R6 held save under stall", {dma_req, dma_restore, dma_slot, dma_tag, busy, free_cnt},
          {1'b1, 1'b0, 2'd1, 8'd40, 1'b1, 3'd0});
    evt_valid = 1'b0;
    dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    check(rsp_valid && !rsp_err && rsp_slot == 2'd1 && !busy, "R3 after stalled ack",
          {rsp_valid, rsp_err, rsp_slot}, {1'b1, 1'b0, 2'd1});

    // R9 priority: complete 50 and new 70 offered together
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = 2'd2; evt_tag = 8'd50;
    new_valid = 1'b1; new_tag = 8'd70;
    @(negedge clk); evt_valid = 1'b0;
    check(free_cnt == 3'd1 && !rsp_valid, "R9 event taken first",
          {free_cnt, rsp_valid}, {3'd1, 1'b0});
    @(negedge clk); new_valid = 1'b0;
    check(rsp_valid && !rsp_err && rsp_slot == 2'd2 && free_cnt == 3'd0, "R9 new taken later",
          {rsp_valid, rsp_err, rsp_slot, free_cnt}, {1'b1, 1'b0, 2'd2, 3'd0});

    // R10 code 3 has no effect; a later reconnect of 20 still hits slot0
    do_op(1'b0, 2'd3, 8'd20, g);
    check(!g.rv && !g.sv && !g.rs && g.free == 8'd0, "R10 code 3 ignored",
          128'(g), 128'd0);
    do_op(1'b0, 2'd1, 8'd20, g);
    check(g.rv && g.hit && g.slot == 8'd0 && !g.sv && !g.rs, "R10 reconnect still hits",
          {g.rv, g.hit, g.slot}, {1'b1, 1'b1, 8'd0});

    // R1 reset in the middle of a save
    do_op(1'b0, 2'd0, 8'd20, g);
    @(negedge clk); new_valid = 1'b1; new_tag = 8'd80;
    @(negedge clk); new_valid = 1'b0;
    check(dma_req && dma_slot == 2'd0 && dma_tag == 8'd20, "R3 save before reset",
          {dma_req, dma_slot, dma_tag}, {1'b1, 2'd0, 8'd20});
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(free_cnt == 3'(N) && !dma_req && !busy && new_ready && !rsp_valid,
          "R1 reset mid-operation", {free_cnt, dma_req, busy, new_ready},
          {3'(N), 3'b001});

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule